// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

This block is a purely combinational integer arithmetic and logic unit. It is assembled from a row of identical one-bit cells that are chained through their carries. Every cell receives the same operation code. Each cell forms the AND, the OR and the full-adder sum of its two operand bits, and it hands on the value that the code selects. Around this row sit two zero-filling barrel shifters, a path for an upper-half immediate, and a less-than path. Both less-than variants use the same adder, which runs in subtract mode for them.

The datapath that surrounds the unit presents two operands, a 4-bit operation code and a shift amount, and it reads back the result in the same cycle. A separate mode input marks the add and subtract instructions that must never trap. For those instructions the overflow flag is held low, while the arithmetic result stays exactly the same as in the signed form. The zero flag is raised whenever the result is all zeros.

Top module: `slice_alu`

## Requirements
- R1: With op_sel 0 the result is op_a AND op_b, and with op_sel 1 the result is op_a OR op_b, bit by bit.
- R2: With op_sel 2 the result is op_a + op_b modulo 2^32. The carry out of bit 31 is dropped.
- R3: With op_sel 6 the result is op_a + ~op_b + 1 modulo 2^32, which equals op_a − op_b.
- R4: When unsigned_mode is 0, ovf is 1 for op_sel 2 and op_sel 6 exactly when the carry into bit 31 differs from the carry out of bit 31. This is the case when the true signed result does not fit in 32 bits.
- R5: When unsigned_mode is 1, ovf is 0 for every operation, and the result is the same as with unsigned_mode 0.
- R6: With op_sel 7 the result is 1 if op_a < op_b as two's-complement numbers, and 0 otherwise. Bits 31:1 are always 0.
- R7: With op_sel 8 the result is 1 if op_a < op_b as unsigned numbers, and 0 otherwise.
- R8: With op_sel 11 the result is {op_b[15:0], 16'h0000}.
- R9: With op_sel 9 the result is op_a shifted left by shamt (0 to 31), and the vacated bits are filled with zeros.
- R10: With op_sel 10 the result is op_a shifted right logically by shamt (0 to 31), and the vacated bits are filled with zeros.
- R11: zero is 1 exactly when all 32 result bits are 0.
- R12: For every op_sel other than 2 and 6, ovf is 0. Any op_sel that is not listed above gives a result of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 32 | First operand; also the value that is shifted |
| op_b | input | 32 | Second operand; its low half is the immediate for op_sel 11 |
| op_sel | input | 4 | Operation code, sent to every bit cell |
| shamt | input | 5 | Shift distance for op_sel 9 and 10 |
| unsigned_mode | input | 1 | Holds overflow reporting low (non-trapping add and subtract) |
| result | output | 32 | Operation result |
| ovf | output | 1 | Signed overflow of an add or subtract |
| zero | output | 1 | Result is all zeros |

## Verification
The checker evaluates its properties whenever the inputs change. It therefore assumes that every input is a known 0 or 1, and that all inputs change together as one vector, with no partial updates. The bench drives the whole input set at once from a single task at the falling clock edge, starts from known values, and never drives X or Z. It also keeps each vector steady until it has been compared. The shift amount is a 5-bit value, so every value it can take is a legal shift distance. No range assumption is needed for it.

// File: rtl/alu_pkg.sv
package alu_pkg;

  typedef enum logic [3:0] {
    OP_AND  = 4'd0,
    OP_OR   = 4'd1,
    OP_ADD  = 4'd2,
    OP_SUB  = 4'd6,
    OP_SLT  = 4'd7,
    OP_SLTU = 4'd8,
    OP_SLL  = 4'd9,
    OP_SRL  = 4'd10,
    OP_LUI  = 4'd11
  } alu_op_e;

  // full adder, one bit
  function automatic logic [1:0] fa_bit(input logic x, input logic y, input logic c);
    fa_bit = {(x & y) | (c & (x ^ y)), x ^ y ^ c};
  endfunction

  // signed overflow from the carries around the sign position
  function automatic logic carry_ovf(input logic c_into_msb, input logic c_out_msb);
    carry_ovf = c_into_msb ^ c_out_msb;
  endfunction

  // signed less-than from the difference sign corrected by overflow
  function automatic logic less_signed(input logic diff_msb, input logic ovf_raw);
    less_signed = diff_msb ^ ovf_raw;
  endfunction

  // unsigned less-than: no carry out of a + ~b + 1 means a borrow happened
  function automatic logic less_unsigned(input logic c_out_msb);
    less_unsigned = ~c_out_msb;
  endfunction

endpackage

// File: rtl/alu_slice.sv
module alu_slice
  import alu_pkg::*;
(
  input  alu_op_e op,
  input  logic    a,
  input  logic    b,
  input  logic    inv_b,
  input  logic    ci,
  output logic    sum,
  output logic    co,
  output logic    res
);

  logic       b_eff;
  logic [1:0] fa;
  logic       and_bit;
  logic       or_bit;

  assign b_eff   = b ^ inv_b;
  assign fa      = fa_bit(a, b_eff, ci);
  assign sum     = fa[0];
  assign co      = fa[1];
  assign and_bit = a & b;
  assign or_bit  = a | b;

  always_comb begin
    unique case (op)
      OP_AND:                       res = and_bit;
      OP_OR:                        res = or_bit;
      OP_ADD, OP_SUB, OP_SLT, OP_SLTU: res = sum;
      default:                      res = 1'b0;
    endcase
  end

endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
  parameter int WIDTH  = 32,
  parameter int SH_W   = $clog2(WIDTH),
  parameter bit LEFT   = 1'b1
) (
  input  logic [WIDTH-1:0] din,
  input  logic [SH_W-1:0]  amt,
  output logic [WIDTH-1:0] dout
);

  for (genvar k = 0; k < SH_W; k++) begin : stg
    localparam int STEP = 1 << k;
    logic [WIDTH-1:0] prev;
    logic [WIDTH-1:0] v;
    if (k == 0) begin : g_first
      assign prev = din;
    end else begin : g_next
      assign prev = stg[k-1].v;
    end
    if (LEFT) begin : g_left
      assign v = amt[k] ? (prev << STEP) : prev;
    end else begin : g_right
      assign v = amt[k] ? (prev >> STEP) : prev;
    end
  end

  assign dout = stg[SH_W-1].v;

endmodule

// File: rtl/slice_alu.sv
module slice_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int SH_W  = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [3:0]       op_sel,
  input  logic [SH_W-1:0]  shamt,
  input  logic             unsigned_mode,
  output logic [WIDTH-1:0] result,
  output logic             ovf,
  output logic             zero
);

  localparam int HALF = WIDTH / 2;

  alu_op_e          op;
  logic             sub_mode;
  logic             is_arith;
  logic [WIDTH-1:0] slice_res;
  logic [WIDTH-1:0] sum_vec;
  logic [WIDTH-1:0] shl_val;
  logic [WIDTH-1:0] shr_val;
  logic             carry_into_msb;
  logic             carry_out_msb;
  logic             ovf_raw;
  logic             lt_signed;
  logic             lt_unsigned;

  assign op       = alu_op_e'(op_sel);
  assign sub_mode = (op == OP_SUB) || (op == OP_SLT) || (op == OP_SLTU);
  assign is_arith = (op == OP_ADD) || (op == OP_SUB);

  // ripple row of identical cells, opcode broadcast to each
  for (genvar i = 0; i < WIDTH; i++) begin : slc
    logic ci;
    logic co;
    logic r;
    logic s;
    if (i == 0) begin : g_lsb
      assign ci = sub_mode;
    end else begin : g_chain
      assign ci = slc[i-1].co;
    end
    alu_slice u_bit (
      .op    (op),
      .a     (op_a[i]),
      .b     (op_b[i]),
      .inv_b (sub_mode),
      .ci    (ci),
      .sum   (s),
      .co    (co),
      .res   (r)
    );
    assign slice_res[i] = r;
    assign sum_vec[i]   = s;
  end

  assign carry_into_msb = slc[WIDTH-1].ci;
  assign carry_out_msb  = slc[WIDTH-1].co;
  assign ovf_raw        = carry_ovf(carry_into_msb, carry_out_msb);
  assign lt_signed      = less_signed(sum_vec[WIDTH-1], ovf_raw);
  assign lt_unsigned    = less_unsigned(carry_out_msb);

  alu_shift #(.WIDTH(WIDTH), .SH_W(SH_W), .LEFT(1'b1)) u_shl (
    .din  (op_a),
    .amt  (shamt),
    .dout (shl_val)
  );

  alu_shift #(.WIDTH(WIDTH), .SH_W(SH_W), .LEFT(1'b0)) u_shr (
    .din  (op_a),
    .amt  (shamt),
    .dout (shr_val)
  );

  always_comb begin
    case (op)
      OP_AND, OP_OR, OP_ADD, OP_SUB: result = slice_res;
      OP_SLT:  result = {{(WIDTH-1){1'b0}}, lt_signed};
      OP_SLTU: result = {{(WIDTH-1){1'b0}}, lt_unsigned};
      OP_SLL:  result = shl_val;
      OP_SRL:  result = shr_val;
      OP_LUI:  result = {op_b[HALF-1:0], {HALF{1'b0}}};
      default: result = '0;
    endcase
  end

  assign ovf  = is_arith & ovf_raw & ~unsigned_mode;
  assign zero = ~|result;

endmodule

// File: rtl/alu_checker.sv
module alu_checker #(
  parameter int WIDTH = 32,
  parameter int SH_W  = $clog2(WIDTH)
) (
  input logic [WIDTH-1:0] op_a,
  input logic [WIDTH-1:0] op_b,
  input logic [3:0]       op_sel,
  input logic [SH_W-1:0]  shamt,
  input logic             unsigned_mode,
  input logic [WIDTH-1:0] result,
  input logic             ovf,
  input logic             zero,
  input logic             c_in_msb,
  input logic             c_out_msb
);

  localparam int HALF = WIDTH / 2;

  always_comb begin
    if (op_sel == 4'd6) begin
      AST_SUB_EQUAL_ZERO: assert (zero == (op_a == op_b)); // R11
    end
    if (unsigned_mode) begin
      AST_NO_OVERFLOW: assert (!ovf); // R5
    end
    if (op_sel != 4'd2 && op_sel != 4'd6) begin
      AST_OVF_ARITH_ONLY: assert (!ovf); // R12
    end
    if (ovf) begin
      AST_OVF_CARRY_DIFF: assert (c_in_msb != c_out_msb); // R4
    end
    if (op_sel == 4'd7 || op_sel == 4'd8) begin
      AST_SLT_BOOLEAN: assert (result[WIDTH-1:1] == '0); // R6
    end
    if (op_sel == 4'd11) begin
      AST_LUI_LOW_CLEAR: assert (result[HALF-1:0] == '0); // R8
    end
    if (op_sel == 4'd9 && shamt == '0) begin
      AST_SHIFT_NOP: assert (result == op_a); // R9
    end
    if (op_sel == 4'd2 && op_b == '0) begin
      AST_ADD_IDENTITY: assert (result == op_a && !ovf); // R2
    end
  end

endmodule

bind slice_alu alu_checker #(.WIDTH(WIDTH), .SH_W(SH_W)) u_alu_chk (
  .op_a          (op_a),
  .op_b          (op_b),
  .op_sel        (op_sel),
  .shamt         (shamt),
  .unsigned_mode (unsigned_mode),
  .result        (result),
  .ovf           (ovf),
  .zero          (zero),
  .c_in_msb      (carry_into_msb),
  .c_out_msb     (carry_out_msb)
);

// File: tb/test_slice_alu.sv
module test_slice_alu;

  localparam int CLK_PERIOD = 10;
  localparam int NVAL       = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] op_a = '0;
  logic [31:0] op_b = '0;
  logic [3:0]  op_sel = '0;
  logic [4:0]  shamt = '0;
  logic        unsigned_mode = 1'b0;
  logic [31:0] result;
  logic        ovf;
  logic        zero;

  int vectors = 0;
  int fails   = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slice_alu i_slice_alu (
    .op_a          (op_a),
    .op_b          (op_b),
    .op_sel        (op_sel),
    .shamt         (shamt),
    .unsigned_mode (unsigned_mode),
    .result        (result),
    .ovf           (ovf),
    .zero          (zero)
  );

  function automatic logic [31:0] pick(input int k);
    case (k)
      0: pick = 32'h0000_0000;
      1: pick = 32'h0000_0001;
      2: pick = 32'hFFFF_FFFF;
      3: pick = 32'h7FFF_FFFF;
      4: pick = 32'h8000_0000;
      5: pick = 32'h8000_0001;
      6: pick = 32'h5555_5555;
      7: pick = 32'hAAAA_AAAA;
      8: pick = 32'h0001_2345;
      default: pick = 32'hFFFE_DCBA;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] o);
    case (o)
      4'd0, 4'd1: tag_of = "R1";
      4'd2:  tag_of = "R2";
      4'd6:  tag_of = "R3";
      4'd7:  tag_of = "R6";
      4'd8:  tag_of = "R7";
      4'd9:  tag_of = "R9";
      4'd10: tag_of = "R10";
      4'd11: tag_of = "R8";
      default: tag_of = "R12";
    endcase
  endfunction

  task automatic apply(input logic [31:0] a, input logic [31:0] b,
                       input logic [3:0] o, input logic [4:0] s, input logic um);
    logic [32:0] wide;
    logic [31:0] exp_r;
    logic        exp_v;
    @(negedge clk);
    op_a = a; op_b = b; op_sel = o; shamt = s; unsigned_mode = um;
    exp_v = 1'b0;
    case (o)
      4'd0: exp_r = a & b;
      4'd1: exp_r = a | b;
      4'd2: begin
        wide  = {1'b0, a} + {1'b0, b};
        exp_r = wide[31:0];
        exp_v = (a[31] == b[31]) && (exp_r[31] != a[31]);
      end
      4'd6: begin
        exp_r = a - b;
        exp_v = (a[31] != b[31]) && (exp_r[31] != a[31]);
      end
      4'd7:  exp_r = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      4'd8:  exp_r = (a < b) ? 32'd1 : 32'd0;
      4'd9:  exp_r = a << s;
      4'd10: exp_r = a >> s;
      4'd11: exp_r = {b[15:0], 16'h0000};
      default: exp_r = 32'h0;
    endcase
    if (um) exp_v = 1'b0;
    @(posedge clk);
    #1;
    vectors++;
    if (result !== exp_r) begin
      fails++;
      $display("FAIL %s result op=%0d a=%h b=%h sh=%0d: actual=%h expected=%h",
               tag_of(o), o, a, b, s, result, exp_r);
    end
    if (ovf !== exp_v) begin
      fails++;
      $display("FAIL %s ovf op=%0d a=%h b=%h um=%0b: actual=%0b expected=%0b",
               um ? "R5" : ((o == 4'd2 || o == 4'd6) ? "R4" : "R12"),
               o, a, b, um, ovf, exp_v);
    end
    if (zero !== (exp_r == 32'h0)) begin
      fails++;
      $display("FAIL R11 zero op=%0d a=%h b=%h: actual=%0b expected=%0b",
               o, a, b, zero, (exp_r == 32'h0));
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset state: idle inputs give AND of zeros (R1, R11)
    apply(32'h0, 32'h0, 4'd0, 5'd0, 1'b0);
    // full sweep of codes, operand corners and both modes
    for (int um = 0; um < 2; um++) begin
      for (int o = 0; o < 16; o++) begin
        for (int ai = 0; ai < NVAL; ai++) begin
          for (int bi = 0; bi < NVAL; bi++) begin
            apply(pick(ai), pick(bi), 4'(o), 5'((ai * 3 + bi * 7) % 32), 1'(um));
          end
        end
      end
    end
    // every shift distance, both directions (R9, R10)
    for (int s = 0; s < 32; s++) begin
      apply(32'h8000_0001, 32'h0, 4'd9,  5'(s), 1'b0);
      apply(32'h8000_0001, 32'h0, 4'd10, 5'(s), 1'b0);
      apply(32'hFFFF_FFFF, 32'h0, 4'd9,  5'(s), 1'b0);
      apply(32'hFFFF_FFFF, 32'h0, 4'd10, 5'(s), 1'b0);
    end
    // overflow edges (R4) and unsigned suppression with same result (R5)
    apply(32'h7FFF_FFFF, 32'h0000_0001, 4'd2, 5'd0, 1'b0);
    apply(32'h7FFF_FFFF, 32'h0000_0001, 4'd2, 5'd0, 1'b1);
    apply(32'h8000_0000, 32'h0000_0001, 4'd6, 5'd0, 1'b0);
    apply(32'h8000_0000, 32'h0000_0001, 4'd6, 5'd0, 1'b1);
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd2, 5'd0, 1'b0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL R2 watchdog: actual=hung expected=complete");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

endmodule